// File: doc/BRIEF.md
# D-PHY Receiver Test-Port Configuration Sequencer

This block sets up a MIPI D-PHY receiver by writing its internal registers over the PHY's serial test port. The port has four signals: a clear line, a test clock, an enable and an 8-bit data bus. A one-cycle `start` pulse supplies a lane count and a link bit rate. The block maps the rate to a 6-bit band code through a parameter table. It then pulses the clear line, performs a fixed series of two-phase register writes, and ends with a one-cycle `done` pulse.

If the rate falls in no table range, or the lane count is not 1, 2 or 4, the block does not move the test port. It raises a one-cycle `error` pulse instead. The lane-enable outputs take the lane mask when a configuration is accepted. The turn-disable outputs are always driven high and the turn-request outputs always low.

Top module: `phy_cfg_seq`

## Requirements
- R1: Each register write has four steps, and each step holds its levels for HOLD_CYCLES clocks. The steps are: testClk=1 with testEn=1 and testDin=address; then testClk=0, whose falling edge captures the address; then testEn=0 with testDin=data; then testClk=1, whose rising edge captures the data.
- R2: In the cycle after the start is captured, testClk and testClr both go high. testClr stays high for exactly CLR_CYCLES clocks. It then stays low, with testClk still high, for SETTLE_CYCLES clocks before the first write begins.
- R3: The writes run in this order: address 0x34 with data 0x15 first, then the per-lane writes, and last address 0x00 with data 0xFF.
- R4: The per-lane writes carry the band code, zero-extended to 8 bits. They go to 0x44 for one lane; to 0x44 then 0x54 for two lanes; and to 0x44, 0x54, 0x84, 0x94 in that order for four lanes.
- R5: The band code comes from the lowest-index table entry whose bounds satisfy low < rate <= high.
- R6: laneEn becomes (1<<lanes)-1 one cycle after an accepted valid start. turnDisable is always 4'hF and turnRequest is always 4'h0.
- R7: A rate that matches no table entry, or a lane count other than 1, 2 or 4, gives a one-cycle error pulse two cycles after start is sampled. In that case testClr, testClk, testEn, testDin and laneEn do not change.
- R8: done is high for exactly one cycle, right after the last hold of the final write. At that point testClk=1, testEn=0 and testDin=0xFF, and these levels remain afterwards.
- R9: A start pulse is ignored while a sequence is in progress, and also in the cycle that shows done or error.
- R10: During and right after reset, all test-port outputs, laneEn, done and error are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to configure |
| laneCount | input | 3 | Number of active lanes (1, 2 or 4) |
| bitRate | input | RATE_W | Link bit rate used for the band lookup |
| testClr | output | 1 | Test-port clear line |
| testClk | output | 1 | Test-port clock |
| testEn | output | 1 | Test-port enable (high: address phase) |
| testDin | output | 8 | Test-port address/data bus |
| laneEn | output | 4 | Per-lane enable mask |
| turnDisable | output | 4 | Per-lane turnaround disable, all high |
| turnRequest | output | 4 | Per-lane turnaround request, all low |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |

## Verification
A wrong phase, write index or hold count in the sequencer shows up within one hold window. It appears either as a testClk edge with the wrong testEn level or as a testDin value that differs from the cycle-by-cycle model. A bad band lookup or a wrong lane decode becomes visible when the write log is decoded from the test-port edges: the address/data pairs are wrong once the first per-lane write completes. A wrong clear-timer count moves the testClr fall and every later edge, so the mismatch appears within CLR_CYCLES clocks of the start.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  localparam logic [7:0] ADDR_INIT  = 8'h34;
  localparam logic [7:0] DATA_INIT  = 8'h15;
  localparam logic [7:0] ADDR_FINAL = 8'h00;
  localparam logic [7:0] DATA_FINAL = 8'hFF;
  localparam logic [7:0] NO_BAND    = 8'hFF;  // sentinel: rate not in any range
  localparam int         LANES_MAX  = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_CLR, S_SETTLE, S_WRITE, S_DONE, S_FAIL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;  // latch lane count and band lookup
    logic       clrOn;    // raise clear and clock, load lane mask
    logic       clrOff;   // drop clear
    logic       drive;    // drive test pins for phase/wrIdx
    logic [1:0] phase;
    logic [2:0] wrIdx;
  } seqCmd_t;

  function automatic logic [7:0] laneAddr(input logic [1:0] lane);
    case (lane)
      2'd0:    laneAddr = 8'h44;
      2'd1:    laneAddr = 8'h54;
      2'd2:    laneAddr = 8'h84;
      default: laneAddr = 8'h94;
    endcase
  endfunction

endpackage

// File: rtl/phy_cfg_dp.sv
module phy_cfg_dp
  import phy_cfg_pkg::*;
#(
  parameter int RATE_W    = 16,
  parameter int NUM_BANDS = 8,
  parameter logic [NUM_BANDS*RATE_W-1:0] BAND_LO   = '0,
  parameter logic [NUM_BANDS*RATE_W-1:0] BAND_HI   = '0,
  parameter logic [NUM_BANDS*6-1:0]      BAND_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCmd_t           cmd,
  input  logic [2:0]        cfgLanes,
  input  logic [RATE_W-1:0] cfgRate,
  output logic              cfgOk,
  output logic [2:0]        lastIdx,
  output logic              testClr,
  output logic              testClk,
  output logic              testEn,
  output logic [7:0]        testDin,
  output logic [3:0]        laneEn
);

  logic [7:0] bandSel;
  logic [5:0] bandReg;
  logic [2:0] laneNum;
  logic       okReg;
  logic       lanesValid;
  logic [3:0] laneMask;
  logic [7:0] wAddr, wData;

  // first matching entry in index order wins
  always_comb begin
    bandSel = NO_BAND;
    for (int i = 0; i < NUM_BANDS; i++) begin
      if (bandSel == NO_BAND &&
          cfgRate >  BAND_LO[i*RATE_W +: RATE_W] &&
          cfgRate <= BAND_HI[i*RATE_W +: RATE_W])
        bandSel = {2'b00, BAND_CODE[i*6 +: 6]};
    end
  end

  assign lanesValid = (cfgLanes == 3'd1) || (cfgLanes == 3'd2) || (cfgLanes == 3'd4);

  always_comb begin
    case (laneNum)
      3'd1:    laneMask = 4'b0001;
      3'd2:    laneMask = 4'b0011;
      3'd4:    laneMask = 4'b1111;
      default: laneMask = 4'b0000;
    endcase
  end

  assign lastIdx = laneNum + 3'd1;
  assign cfgOk   = okReg;

  always_comb begin
    if (cmd.wrIdx == 3'd0) begin
      wAddr = ADDR_INIT;
      wData = DATA_INIT;
    end else if (cmd.wrIdx == lastIdx) begin
      wAddr = ADDR_FINAL;
      wData = DATA_FINAL;
    end else begin
      wAddr = laneAddr(2'(cmd.wrIdx - 3'd1));
      wData = {2'b00, bandReg};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bandReg <= '0;
      laneNum <= '0;
      okReg   <= 1'b0;
      testClr <= 1'b0;
      testClk <= 1'b0;
      testEn  <= 1'b0;
      testDin <= '0;
      laneEn  <= '0;
    end else begin
      if (cmd.capture) begin
        bandReg <= bandSel[5:0];
        laneNum <= cfgLanes;
        okReg   <= lanesValid && (bandSel != NO_BAND);
      end
      if (cmd.clrOn) begin
        testClr <= 1'b1;
        testClk <= 1'b1;
        laneEn  <= laneMask;
      end
      if (cmd.clrOff) testClr <= 1'b0;
      if (cmd.drive) begin
        testClk <= (cmd.phase == 2'd0) || (cmd.phase == 2'd3);
        testEn  <= (cmd.phase == 2'd0) || (cmd.phase == 2'd1);
        testDin <= cmd.phase[1] ? wData : wAddr;
      end
    end
  end

endmodule

// File: rtl/phy_cfg_ctl.sv
module phy_cfg_ctl
  import phy_cfg_pkg::*;
#(
  parameter int CLR_CYCLES    = 25000,
  parameter int SETTLE_CYCLES = 25000,
  parameter int HOLD_CYCLES   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       cfgOk,
  input  logic [2:0] lastIdx,
  output seqCmd_t    cmd,
  output logic       done,
  output logic       error
);

  localparam int CNT_A   = (CLR_CYCLES > SETTLE_CYCLES) ? CLR_CYCLES : SETTLE_CYCLES;
  localparam int CNT_MAX = (CNT_A > HOLD_CYCLES) ? CNT_A : HOLD_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CLR_END    = CNT_W'(CLR_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_END   = CNT_W'(HOLD_CYCLES - 1);

  seqState_t        state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [1:0]       phase, phaseN;
  logic [2:0]       idx, idxN;

  always_comb begin
    cmd    = '0;
    stateN = state;
    cntN   = cnt + 1'b1;
    phaseN = phase;
    idxN   = idx;
    case (state)
      S_IDLE: begin
        cntN = '0;
        if (start) begin
          cmd.capture = 1'b1;
          stateN      = S_CHECK;
        end
      end
      S_CHECK: begin
        cntN = '0;
        if (cfgOk) begin
          cmd.clrOn = 1'b1;
          stateN    = S_CLR;
        end else begin
          stateN = S_FAIL;
        end
      end
      S_CLR: if (cnt == CLR_END) begin
        cmd.clrOff = 1'b1;
        cntN       = '0;
        stateN     = S_SETTLE;
      end
      S_SETTLE: if (cnt == SETTLE_END) begin
        cntN      = '0;
        phaseN    = 2'd0;
        idxN      = 3'd0;
        cmd.drive = 1'b1;
        stateN    = S_WRITE;
      end
      S_WRITE: if (cnt == HOLD_END) begin
        cntN = '0;
        if (phase != 2'd3) begin
          phaseN    = phase + 2'd1;
          cmd.drive = 1'b1;
        end else if (idx == lastIdx) begin
          stateN = S_DONE;
        end else begin
          idxN      = idx + 3'd1;
          phaseN    = 2'd0;
          cmd.drive = 1'b1;
        end
      end
      default: begin
        cntN   = '0;
        stateN = S_IDLE;
      end
    endcase
    cmd.phase = phaseN;
    cmd.wrIdx = idxN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      phase <= '0;
      idx   <= '0;
    end else begin
      state <= stateN;
      cnt   <= cntN;
      phase <= phaseN;
      idx   <= idxN;
    end
  end

  assign done  = (state == S_DONE);
  assign error = (state == S_FAIL);

endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
  import phy_cfg_pkg::*;
#(
  parameter int RATE_W        = 16,
  parameter int NUM_BANDS     = 8,
  parameter logic [NUM_BANDS*RATE_W-1:0] BAND_LO =
    {16'd170, 16'd150, 16'd140, 16'd130, 16'd110, 16'd100, 16'd90, 16'd80},
  parameter logic [NUM_BANDS*RATE_W-1:0] BAND_HI =
    {16'd180, 16'd170, 16'd150, 16'd140, 16'd130, 16'd110, 16'd100, 16'd90},
  parameter logic [NUM_BANDS*6-1:0] BAND_CODE =
    {6'h12, 6'h02, 6'h21, 6'h11, 6'h01, 6'h20, 6'h10, 6'h00},
  parameter int CLR_CYCLES    = 25000,
  parameter int SETTLE_CYCLES = 25000,
  parameter int HOLD_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        laneCount,
  input  logic [RATE_W-1:0] bitRate,
  output logic              testClr,
  output logic              testClk,
  output logic              testEn,
  output logic [7:0]        testDin,
  output logic [3:0]        laneEn,
  output logic [3:0]        turnDisable,
  output logic [3:0]        turnRequest,
  output logic              done,
  output logic              error
);

  seqCmd_t    cmd;
  logic       cfgOk;
  logic [2:0] lastIdx;

  phy_cfg_ctl #(
    .CLR_CYCLES(CLR_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)
  ) uCtl (
    .clk(clk), .rst(rst), .start(start), .cfgOk(cfgOk), .lastIdx(lastIdx),
    .cmd(cmd), .done(done), .error(error)
  );

  phy_cfg_dp #(
    .RATE_W(RATE_W), .NUM_BANDS(NUM_BANDS),
    .BAND_LO(BAND_LO), .BAND_HI(BAND_HI), .BAND_CODE(BAND_CODE)
  ) uDp (
    .clk(clk), .rst(rst), .cmd(cmd), .cfgLanes(laneCount), .cfgRate(bitRate),
    .cfgOk(cfgOk), .lastIdx(lastIdx),
    .testClr(testClr), .testClk(testClk), .testEn(testEn), .testDin(testDin),
    .laneEn(laneEn)
  );

  assign turnDisable = {LANES_MAX{1'b1}};
  assign turnRequest = {LANES_MAX{1'b0}};

endmodule

// File: rtl/phy_cfg_chk.sv
module phy_cfg_chk (
  input logic       clk,
  input logic       rst,
  input logic       testClr,
  input logic       testClk,
  input logic       testEn,
  input logic [7:0] testDin,
  input logic [3:0] laneEn,
  input logic       done,
  input logic       error
);

  AST_ADDR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(testClk) |-> (testEn && $stable(testDin)));  // R1
  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(testClk) |-> !testEn);  // R1
  AST_CLR_WITH_CLK: assert property (@(posedge clk) disable iff (rst)
    testClr |-> testClk);  // R2
  AST_LANE_MASK: assert property (@(posedge clk) disable iff (rst)
    (laneEn == 4'h0) || (laneEn == 4'h1) || (laneEn == 4'h3) || (laneEn == 4'hF));  // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    error |-> $stable({testClr, testClk, testEn, testDin, laneEn}));  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
  AST_DONE_LEVELS: assert property (@(posedge clk) disable iff (rst)
    done |-> (testClk && !testEn && !testClr && testDin == 8'hFF));  // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && error));  // R8

endmodule

bind phy_cfg_seq phy_cfg_chk u_chk (
  .clk(clk), .rst(rst), .testClr(testClr), .testClk(testClk), .testEn(testEn),
  .testDin(testDin), .laneEn(laneEn), .done(done), .error(error)
);

// File: tb/sim_phy_cfg_seq.sv
module sim_phy_cfg_seq;

  localparam int CLRC = 20;
  localparam int SETC = 12;
  localparam int HOLD = 3;

  typedef struct packed {
    logic       clk;
    logic       clr;
    logic       en;
    logic [7:0] din;
    logic       done;
    logic       err;
    logic [3:0] lane;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  laneCount = '0;
  logic [15:0] bitRate = '0;
  logic        testClr, testClk, testEn, done, error;
  logic [7:0]  testDin;
  logic [3:0]  laneEn, turnDisable, turnRequest;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  rec_t       expQ[$];
  rec_t       cur;
  bit         prevPulse = 0;
  logic [15:0] logQ[$];
  logic [15:0] expLog[$];
  logic       pClk = 1'b0;
  logic       pend = 1'b0;
  logic [7:0] pendAddr = '0;

  int loT[4]   = '{100, 200, 150, 400};
  int hiT[4]   = '{200, 400, 300, 1000};
  int codeT[4] = '{'h05, 'h0A, 'h3F, 'h2C};
  int laneA[4] = '{'h44, 'h54, 'h84, 'h94};

  always #2 clk = ~clk;

  phy_cfg_seq #(
    .RATE_W(16), .NUM_BANDS(4),
    .BAND_LO({16'd400, 16'd150, 16'd200, 16'd100}),
    .BAND_HI({16'd1000, 16'd300, 16'd400, 16'd200}),
    .BAND_CODE({6'h2C, 6'h3F, 6'h0A, 6'h05}),
    .CLR_CYCLES(CLRC), .SETTLE_CYCLES(SETC), .HOLD_CYCLES(HOLD)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .laneCount(laneCount), .bitRate(bitRate),
    .testClr(testClr), .testClk(testClk), .testEn(testEn), .testDin(testDin),
    .laneEn(laneEn), .turnDisable(turnDisable), .turnRequest(turnRequest),
    .done(done), .error(error)
  );

  function automatic int lookup(int r);  // R5: first index with lo < r <= hi
    for (int i = 0; i < 4; i++)
      if (r > loT[i] && r <= hiT[i]) return codeT[i];
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step();
    rec_t e;
    bit any;
    @(negedge clk);
    cyc++;
    if (expQ.size() > 0) e = expQ.pop_front();
    else begin e = cur; e.done = 0; e.err = 0; end
    prevPulse = e.done | e.err;
    any = 0;
    total++;
    if (testClr !== e.clr) begin any = 1; $display("FAIL R2 testClr: actual=%0b expected=%0b", testClr, e.clr); end
    if (testClk !== e.clk) begin any = 1; $display("FAIL R1 testClk: actual=%0b expected=%0b", testClk, e.clk); end
    if (testEn !== e.en) begin any = 1; $display("FAIL R1 testEn: actual=%0b expected=%0b", testEn, e.en); end
    if (testDin !== e.din) begin any = 1; $display("FAIL R3 testDin: actual=%0h expected=%0h", testDin, e.din); end
    if (done !== e.done) begin any = 1; $display("FAIL R8 done: actual=%0b expected=%0b", done, e.done); end
    if (error !== e.err) begin any = 1; $display("FAIL R7 error: actual=%0b expected=%0b", error, e.err); end
    if (laneEn !== e.lane) begin any = 1; $display("FAIL R6 laneEn: actual=%0h expected=%0h", laneEn, e.lane); end
    if (turnDisable !== 4'hF || turnRequest !== 4'h0) begin
      any = 1; $display("FAIL R6 turn: actual=%0h/%0h expected=f/0", turnDisable, turnRequest);
    end
    if (any) bad++;
    // decode writes from the port edges
    if (pClk && !testClk && testEn) begin pendAddr = testDin; pend = 1; end
    if (!pClk && testClk && !testEn && pend) begin logQ.push_back({pendAddr, testDin}); pend = 0; end
    pClk = testClk;
  endtask

  task automatic pushWrite(inout rec_t e, input logic [7:0] a, input logic [7:0] d);
    expLog.push_back({a, d});
    e.clk = 1; e.en = 1; e.din = a; repeat (HOLD) expQ.push_back(e);
    e.clk = 0;                      repeat (HOLD) expQ.push_back(e);
    e.en = 0; e.din = d;            repeat (HOLD) expQ.push_back(e);
    e.clk = 1;                      repeat (HOLD) expQ.push_back(e);
  endtask

  task automatic launch(int l, int r);
    rec_t e;
    int band;
    bit acc;
    acc = (expQ.size() == 0) && !prevPulse;  // R9
    laneCount = 3'(l);
    bitRate = 16'(r);
    start = 1;
    if (acc) begin
      band = lookup(r);
      e = cur; e.done = 0; e.err = 0;
      expQ.push_back(e);
      if (band < 0 || !(l == 1 || l == 2 || l == 4)) begin
        e.err = 1; expQ.push_back(e);  // R7
      end else begin
        e.clk = 1; e.clr = 1; e.lane = 4'((1 << l) - 1);
        repeat (CLRC) expQ.push_back(e);
        e.clr = 0;
        repeat (SETC) expQ.push_back(e);
        pushWrite(e, 8'h34, 8'h15);
        for (int k = 0; k < l; k++) pushWrite(e, 8'(laneA[k]), 8'(band));
        pushWrite(e, 8'h00, 8'hFF);
        e.done = 1; expQ.push_back(e);
        e.done = 0; cur = e;
      end
    end
    step();
    start = 0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) step();
  endtask

  task automatic verifyLog(string tag);
    bit ok;
    ok = (logQ.size() == expLog.size());
    for (int i = 0; ok && i < logQ.size(); i++) if (logQ[i] !== expLog[i]) ok = 0;
    chk(ok, tag, (logQ.size() > 0) ? int'(logQ[logQ.size()-1]) : -1,
        (expLog.size() > 0) ? int'(expLog[expLog.size()-1]) : -1);
    logQ.delete();
    expLog.delete();
  endtask

  task automatic runCfg(int l, int r, string tag);
    launch(l, r);
    drain();
    step();
    verifyLog(tag);
  endtask

  always @(posedge clk) begin
    if (!finished && cyc > 100000) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R8 watchdog: cycles=%0d expected below 100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({testClr, testClk, testEn, testDin, laneEn, done, error} == '0, "R10 reset outputs",
        int'({testClr, testClk, testEn, testDin, laneEn, done, error}), 0);
    rst = 0;
    cur = '0;
    step();
    chk({testClr, testClk, testEn, testDin, laneEn, done, error} == '0, "R10 after reset",
        int'({testClr, testClk, testEn, testDin, laneEn, done, error}), 0);

    runCfg(1, 150, "R4 one lane writes");            // band 0x05
    runCfg(4, 1000, "R4 four lane upper bound");     // band 0x2C
    runCfg(2, 180, "R5 first match wins");           // 0x05 not 0x3F
    runCfg(4, 200, "R5 upper bound inclusive");      // 0x05
    runCfg(1, 201, "R5 lower bound exclusive");      // 0x0A
    runCfg(2, 250, "R3 write order two lanes");      // 0x0A

    // R7: rejected configurations leave the port untouched
    runCfg(1, 100, "R7 rate at low bound");
    runCfg(2, 1001, "R7 rate above table");
    runCfg(3, 150, "R7 lane count three");
    runCfg(0, 150, "R7 lane count zero");
    chk(laneEn == 4'h3, "R7 laneEn kept", laneEn, 3);

    // R9: start during a running sequence and in the done cycle
    launch(2, 201);
    repeat (30) step();
    launch(4, 1000);
    drain();
    launch(1, 150);
    repeat (4) step();
    verifyLog("R9 busy starts ignored");
    chk(laneEn == 4'h3, "R9 lane mask unchanged", laneEn, 3);

    // R2/R6 after a good run following an error
    runCfg(1, 120, "R6 lane mask one");
    chk(laneEn == 4'h1, "R6 laneEn one lane", laneEn, 1);
    chk(testClk && !testEn && testDin == 8'hFF, "R8 final levels",
        int'({testClk, testEn, testDin}), 'h2FF);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule